// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system use an external asynchronous static RAM of 16K words by 4 bits. On the system side a request is taken while `ready_o` is high. The request carries an address, write data and a direction flag. A read returns its word on `rdata_o` together with a one-cycle `rvalid_o` pulse. On the memory side the block drives the address, the active-low chip select, write strobe and output enable, and a split 4-bit data bus (out, in, drive enable). The pad buffer sits outside the block.

Every strobe phase is sized in clock cycles from the memory's nanosecond limits, using a clock-period parameter and the rule cycles = max(1, ceil(t_ns / period)). Each access passes through a setup cycle, a strobe phase and a closing cycle. A write is ended by the rising edge of the write strobe, and the data and address stay put through that edge. Output enable stays high for the whole of a write. When one access is followed by another of the opposite direction, idle turnaround cycles covering the memory's 8 ns bus release time come before the next setup. The memory is deselected whenever the block is idle.

Top module: `async_sram_ctl`

## Requirements
- R1: In reset and while idle, chip select, write strobe and output enable are high (deselected), the data bus is not driven, `ready_o` is high and `rvalid_o` is low.
- R2: A write runs one setup cycle (chip select low, strobe high, address and data driven), then the write strobe low for N_WP = max(ceil(12/P), ceil(10/P), ceil(15/P)-2, 1) cycles, then one cycle with the strobe high, chip select low and data still driven. With P = 10 ns, N_WP = 2, and `ready_o` returns 2+N_WP cycles after acceptance when there is no turnaround.
- R3: Output enable stays high during every cycle of a write, and the data bus is never driven while output enable is low.
- R4: At the rising edge of the write strobe, the write strobe has been low for at least 12 ns, and the data and address have been unchanged for at least 10 ns and 12 ns respectively.
- R5: A read runs one setup cycle (chip select low, output enable high), then output enable low for N_RD = max(ceil(10/P), ceil(15/P)-1, 1) cycles. The bus is captured at the end of the last such cycle. In the following cycle chip select is high, `rvalid_o` is high for exactly that one cycle and `rdata_o` holds the word. With P = 10 ns, N_RD = 1, and `ready_o` returns 2+N_RD cycles after acceptance when there is no turnaround.
- R6: A read returns the data most recently written to that address, including at addresses 0 and 16383. A location never written reads as 0 in the memory model used here.
- R7: `ready_o` is high only when idle. A request presented while `ready_o` is low is ignored and alters neither the memory nor the timing of the access in progress.
- R8: When an accepted access has the opposite direction to the previous accepted one, N_TURN = ceil(8/P) deselected cycles with the bus undriven come before its setup (N_TURN = 1 at 10 ns). There are none between accesses of the same direction, and none for the first access after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 14 | Word address |
| wdata_i | input | 4 | Write data |
| ready_o | output | 1 | Controller idle, request may be taken |
| rvalid_o | output | 1 | One-cycle pulse: rdata_o valid |
| rdata_o | output | 4 | Captured read data |
| sram_addr_o | output | 14 | Memory address bus |
| sram_ce_no | output | 1 | Memory chip select, active low |
| sram_we_no | output | 1 | Memory write strobe, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_dq_o | output | 4 | Data toward the memory |
| sram_dq_i | input | 4 | Data from the memory |
| sram_dq_oe_o | output | 1 | Drive enable for the data pads |

## Verification
Two things can fall on the same clock edge: acceptance of a new request and the decision to insert turnaround cycles, because the direction of the new request is compared with the previous one in the acceptance cycle. The bench provokes this with back-to-back accesses of random direction over a small address pool and with `req_i` held high through busy periods. It judges each access by its measured latency against 2+N plus N_TURN when the direction flips. A memory model checks strobe width, data and address stability at the write edge and bus contention, and flags late read data by returning inverted bits.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/100ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_SETUP, ST_STROBE, ST_HOLD, ST_RECOV
  } state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pins_t;

  localparam pins_t PINS_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  function automatic int ns2cyc(int t_ns, int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // pin levels for the cycle spent in state s
  function automatic pins_t pins_of(state_e s, logic wr);
    pins_t p;
    p = PINS_OFF;
    case (s)
      ST_SETUP: begin
        p.ce_n  = 1'b0;
        p.dq_oe = wr;
      end
      ST_STROBE: begin
        p.ce_n  = 1'b0;
        p.we_n  = ~wr;
        p.oe_n  = wr;
        p.dq_oe = wr;
      end
      ST_HOLD: begin
        p.ce_n  = 1'b0;
        p.dq_oe = 1'b1;
      end
      default: p = PINS_OFF;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/100ps
module sram_ctl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/100ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int N_WP   = 2,
  parameter int N_RD   = 1,
  parameter int N_TURN = 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  logic  we_i,
  output logic  ready_o,
  output logic  accept_o,
  output logic  capture_o,
  output pins_t pins_o
);

  state_e           state_q, state_d;
  logic             op_we_q, op_we_d;
  logic             prev_vld_q, prev_we_q;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  pins_t            pins_q;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o & req_i;
  assign op_we_d  = accept_o ? we_i : op_we_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        if (prev_vld_q && (prev_we_q != we_i)) begin
          state_d  = ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(N_TURN - 1);
        end else begin
          state_d  = ST_SETUP;
        end
      end
      ST_TURN:  if (tmr_zero) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = op_we_q ? CNT_W'(N_WP - 1) : CNT_W'(N_RD - 1);
      end
      ST_STROBE: if (tmr_zero) state_d = op_we_q ? ST_HOLD : ST_RECOV;
      ST_HOLD:   state_d = ST_IDLE;
      ST_RECOV:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // last read strobe cycle: bus is sampled at its closing edge
  assign capture_o = (state_q == ST_STROBE) && tmr_zero && !op_we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_we_q    <= 1'b0;
      prev_vld_q <= 1'b0;
      prev_we_q  <= 1'b0;
      pins_q     <= PINS_OFF;
    end else begin
      state_q <= state_d;
      op_we_q <= op_we_d;
      pins_q  <= pins_of(state_d, op_we_d);
      if (accept_o) begin
        prev_vld_q <= 1'b1;
        prev_we_q  <= we_i;
      end
    end
  end

  assign pins_o = pins_q;

  sram_ctl_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

endmodule

// File: rtl/sram_ctl_dpath.sv
`timescale 1ns/100ps
module sram_ctl_dpath #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture_i) rdata_q <= dq_i;
    end
  end

  assign addr_o   = addr_q;
  assign dout_o   = wdata_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/async_sram_ctl.sv
`timescale 1ns/100ps
module async_sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 14,
  parameter int DATA_W        = 4,
  parameter int T_WP_NS       = 12,
  parameter int T_WC_NS       = 15,
  parameter int T_SD_NS       = 10,
  parameter int T_AA_NS       = 15,
  parameter int T_DOE_NS      = 10,
  parameter int T_HZ_NS       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o
);

  // strobe covers pulse width and data setup; setup+hold cycles fill the cycle time
  localparam int N_WP = imax(imax(ns2cyc(T_WP_NS, CLK_PERIOD_NS), ns2cyc(T_SD_NS, CLK_PERIOD_NS)),
                             imax(ns2cyc(T_WC_NS, CLK_PERIOD_NS) - 2, 1));
  // address is already valid one cycle before output enable falls
  localparam int N_RD = imax(ns2cyc(T_DOE_NS, CLK_PERIOD_NS),
                             imax(ns2cyc(T_AA_NS, CLK_PERIOD_NS) - 1, 1));
  localparam int N_TURN  = ns2cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int CNT_MAX = imax(N_WP, imax(N_RD, N_TURN));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic  accept, capture;
  pins_t pins;

  sram_ctl_fsm #(
    .CNT_W  (CNT_W),
    .N_WP   (N_WP),
    .N_RD   (N_RD),
    .N_TURN (N_TURN)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .ready_o   (ready_o),
    .accept_o  (accept),
    .capture_o (capture),
    .pins_o    (pins)
  );

  sram_ctl_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_dpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .dq_i      (sram_dq_i),
    .addr_o    (sram_addr_o),
    .dout_o    (sram_dq_o),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  assign sram_ce_no   = pins.ce_n;
  assign sram_we_no   = pins.we_n;
  assign sram_oe_no   = pins.oe_n;
  assign sram_dq_oe_o = pins.dq_oe;

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/100ps
module sram_ctl_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe_o
);

  AST_IDLE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o)); // R1

  AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce_no && sram_dq_oe_o)); // R2

  AST_NO_BUS_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_dq_oe_o && !sram_oe_no)); // R3

  AST_WRITE_EDGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (sram_dq_oe_o && !sram_ce_no && $stable(sram_dq_o) && $stable(sram_addr_o))); // R4

  AST_RVALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R5

  AST_RVALID_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (sram_ce_no && !ready_o)); // R5

  AST_ADDR_HELD_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o)); // R4

endmodule

bind async_sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .rvalid_o     (rvalid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/test_async_sram_ctl.sv
`timescale 1ns/100ps
module test_async_sram_ctl;

  localparam int CLK_NS = 10;
  localparam int AW = 14;
  localparam int DW = 4;

  // memory limits in ns, as stated in the requirements
  localparam int W_PULSE = 12, W_CYCLE = 15, D_SETUP = 10, A_SETUP = 12;
  localparam int R_ADDR = 15, R_OE = 10, BUS_REL = 8;

  function automatic int cyc(int t);
    int c;
    c = (t + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_WP = mx(mx(cyc(W_PULSE), cyc(D_SETUP)), mx(cyc(W_CYCLE) - 2, 1));
  localparam int E_RD = mx(cyc(R_OE), mx(cyc(R_ADDR) - 1, 1));
  localparam int E_TN = cyc(BUS_REL);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, rvalid;
  logic [DW-1:0] rdata;
  logic [AW-1:0] m_addr;
  logic          ce_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] dq_to_mem;
  logic [DW-1:0] dq_from_mem = '0;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  async_sram_ctl i_async_sram_ctl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_i        (req),
    .we_i         (we),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .ready_o      (ready),
    .rvalid_o     (rvalid),
    .rdata_o      (rdata),
    .sram_addr_o  (m_addr),
    .sram_ce_no   (ce_n),
    .sram_we_no   (we_n),
    .sram_oe_no   (oe_n),
    .sram_dq_o    (dq_to_mem),
    .sram_dq_i    (dq_from_mem),
    .sram_dq_oe_o (dq_oe)
  );

  always #(CLK_NS / 2) clk = ~clk;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  // ---------------- behavioural asynchronous SRAM model ----------------
  logic [DW-1:0] mem_m [int];
  logic [DW-1:0] ref_m [int];
  realtime t_oe = 0.0, t_addr = 0.0, t_data = 0.0, t_wfall = 0.0;

  function automatic logic [DW-1:0] mrd(int a);
    return mem_m.exists(a) ? mem_m[a] : '0;
  endfunction
  function automatic logic [DW-1:0] rrd(int a);
    return ref_m.exists(a) ? ref_m[a] : '0;
  endfunction

  always @(negedge oe_n) t_oe = $realtime;
  always @(m_addr) t_addr = $realtime;
  always @(dq_to_mem or dq_oe) t_data = $realtime;

  always @(negedge we_n) begin
    t_wfall = $realtime;
    if (rst_n) check(oe_n === 1'b1, "R3 oe_n at write strobe", int'(oe_n), 1);
  end

  always @(posedge we_n) begin
    if (rst_n && ce_n === 1'b0) begin
      check(($realtime - t_wfall) >= W_PULSE, "R4 strobe width ns", int'($realtime - t_wfall), W_PULSE);
      check(($realtime - t_data) >= D_SETUP && dq_oe, "R4 data setup ns", int'($realtime - t_data), D_SETUP);
      check(($realtime - t_addr) >= A_SETUP, "R4 addr setup ns", int'($realtime - t_addr), A_SETUP);
      mem_m[int'(m_addr)] = dq_to_mem;
    end
  end

  // model output, re-evaluated on a half-ns grid away from clock edges
  initial begin
    #0.5;
    forever begin
      if (!ce_n && !oe_n && we_n) begin
        if (($realtime - t_oe + 0.6) >= R_OE && ($realtime - t_addr + 0.6) >= R_ADDR)
          dq_from_mem = mrd(int'(m_addr));
        else
          dq_from_mem = ~mrd(int'(m_addr));
      end else begin
        dq_from_mem = '0;
      end
      #1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && dq_oe && !oe_n)
      check(1'b0, "R3 bus driven with oe_n low", 1, 0);
  end

  // ---------------- access driver ----------------
  bit have_prev = 1'b0;
  bit prev_w = 1'b0;

  task automatic run_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit hold_req);
    int lat, nval, exp_lat;
    bit turn;
    logic [DW-1:0] got;
    got = '0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    turn = have_prev && (prev_w != w);
    @(posedge clk);
    lat = 0; nval = 0;
    forever begin
      @(negedge clk);
      if (hold_req) begin
        // R7: conflicting request kept up while busy
        req = 1'b1; we = 1'b1; addr = 14'd100; wdata = 4'hA;
      end else begin
        req = 1'b0;
      end
      if (rvalid) begin nval++; got = rdata; end
      if (ready) break;
      lat++;
      if (lat > 50) break;
    end
    req = 1'b0;
    exp_lat = (turn ? E_TN : 0) + 2 + (w ? E_WP : E_RD);
    if (w) begin
      check(lat == exp_lat, turn ? "R8 write latency with turnaround" : "R2 write latency", lat, exp_lat);
      check(nval == 0, "R5 no rvalid on write", nval, 0);
      ref_m[int'(a)] = d;
    end else begin
      check(lat == exp_lat, turn ? "R8 read latency with turnaround" : "R5 read latency", lat, exp_lat);
      check(nval == 1, "R5 rvalid pulse count", nval, 1);
      check(got == rrd(int'(a)), "R6 read data", int'(got), int'(rrd(int'(a))));
    end
    have_prev = 1'b1;
    prev_w = w;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [AW-1:0] pool [8];
    pool[0] = '0; pool[1] = '1; pool[2] = 14'd100; pool[3] = 14'd200;
    pool[4] = 14'd5; pool[5] = 14'h2AAA; pool[6] = 14'h1555; pool[7] = 14'd6;
    void'($urandom(32'd1234));

    #(CLK_NS * 2 + 1);
    check(ready && !rvalid, "R1 ready in reset", int'({ready, rvalid}), 2);
    check(ce_n && we_n && oe_n && !dq_oe, "R1 pins in reset", int'({ce_n, we_n, oe_n, dq_oe}), 14);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe && ready, "R1 idle after reset",
          int'({ce_n, we_n, oe_n, dq_oe, ready}), 29);

    // first access: no turnaround (R8), corner addresses and data (R6)
    run_op(1'b1, '0, 4'hF, 1'b0);
    run_op(1'b1, '1, 4'h0, 1'b0);
    run_op(1'b1, 14'd100, 4'h5, 1'b0);
    run_op(1'b0, '0, 4'h0, 1'b0);
    run_op(1'b0, '1, 4'h0, 1'b0);
    run_op(1'b0, 14'd3333, 4'h0, 1'b0);

    // R7: a write to 100 is held requested while another access is busy
    run_op(1'b1, 14'd200, 4'h3, 1'b1);
    run_op(1'b0, 14'd200, 4'h0, 1'b1);
    run_op(1'b0, 14'd100, 4'h0, 1'b0);
    check(rrd(100) == 4'h5, "R7 busy request ignored", int'(rrd(100)), 5);

    // constrained random mix over a small address pool
    for (int i = 0; i < 300; i++) begin
      bit w;
      w = 1'($urandom % 2);
      run_op(w, pool[$urandom % 8], DW'($urandom), 1'b0);
    end

    // read back every pool address
    for (int i = 0; i < 8; i++) run_op(1'b0, pool[i], 4'h0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule